// File: doc/BRIEF.md
# Parallel Memory Self-Test Sequencer

This block tests one memory target at a time over a parallel address, data and strobe interface. Each target number stands for a group of like devices that share a depth and control behaviour and are exercised together as a single unit. The target number decides what kind of run takes place. Numbers below `NUM_SRAM` are static RAMs and get a 5n march, where n is `DEPTH` words. Number `NUM_SRAM` fills an attached FIFO with a constant word. Number `NUM_SRAM+1` empties that FIFO and checks each word it reads.

There are two ways to start a run. A single-target command tests the number held in the target register. A walk command tests every RAM number in rising order. A RAM whose bit is set in `DUAL_MASK` is tested twice, first through port 0 and then through port 1. The block keeps a sticky data-fail bit together with the target, port and address of the first mismatch. It keeps a separate sticky flag-fail bit for FIFO status errors. It pulses a completion interrupt once at the end of every command.

The memory side is a plain cycle-timed interface with no handshake. Read data must come back on `mem_rdata` one cycle after `mem_re` is high. The FIFO status inputs must be registered, so that they reflect every strobe up to the previous clock edge. No stream interface is present, so no back-pressure rules apply.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, `busy`, `done_irq`, `mem_we`, `mem_re`, `fail` and `flag_fail` are all 0.
- R2: A RAM run on one port takes 5·DEPTH strobe cycles with no gaps, in three passes. Pass one writes 0 at rising addresses. Pass two goes through rising addresses; at each one it reads (expecting 0) and then writes all ones. Pass three goes through falling addresses; at each one it reads (expecting all ones) and then writes 0. The interrupt is high in the (5·DEPTH+2)-th cycle after the command edge.
- R3: A read mismatch sets `fail` and records the target number, port and address in `fail_id`, `fail_port` and `fail_addr`. A later mismatch does not change these. The next accepted command clears them.
- R4: `run_one` tests the target number loaded earlier through `id_load`/`id_value`. A number above `NUM_SRAM+1` makes no strobe and raises the interrupt in the first cycle after the command edge.
- R5: `run_all` ignores the target register. It tests RAM numbers 0 to `NUM_SRAM-1` in rising order and raises a single interrupt at the very end.
- R6: A dual-port RAM gets the full march on port 0 and then the full march on port 1, with `mem_port` showing which port is under test.
- R7: A fill run writes exactly DEPTH words to target `NUM_SRAM`. Each word is all ones if `pat_ones` was 1 when the command was taken, and all zeros otherwise. The interrupt comes in cycle DEPTH+2.
- R8: A drain run reads exactly DEPTH words from target `NUM_SRAM+1` and compares each one against the constant chosen by `pat_ones`. The `fail_addr` of a drain run is the read index, counting from 0.
- R9: Before fill write k, the block expects empty = (k==0) and full = 0. Before drain read k, it expects full = (k==0) and empty = 0. In the cycle after the last strobe, it expects full=1/empty=0 after a fill and empty=1/full=0 after a drain. Any difference sets `flag_fail` only.
- R10: `done_irq` is a one-cycle pulse, given once per command. Commands that arrive while `busy` is high are ignored.
- R11: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_load | input | 1 | Load `id_value` into the target register |
| id_value | input | IDW | Target number to load |
| pat_ones | input | 1 | FIFO constant select: 1 = all ones, 0 = all zeros |
| run_all | input | 1 | Start a walk over all RAM targets |
| run_one | input | 1 | Start a run on the registered target |
| busy | output | 1 | A command is in progress |
| done_irq | output | 1 | Completion pulse |
| mem_id | output | IDW | Target number being driven |
| mem_port | output | 1 | Port under test |
| mem_addr | output | AW | Word address, or the FIFO strobe index |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after `mem_re` |
| fifo_full | input | 1 | FIFO full status |
| fifo_empty | input | 1 | FIFO empty status |
| fail | output | 1 | Sticky data mismatch |
| fail_addr | output | AW | Address or index of the first mismatch |
| fail_id | output | IDW | Target number of the first mismatch |
| fail_port | output | 1 | Port of the first mismatch |
| flag_fail | output | 1 | Sticky FIFO status mismatch |

## Verification
A wrong sequencer state shows up on the strobes in the very cycle it happens: a missing pass, a reversed direction or a skipped port changes the address and data seen on the next strobe. It also moves the interrupt away from its fixed cycle count. A faulty capture register shows up in `fail_addr` or `fail_id` when the interrupt arrives. The sweep puts a stuck bit at every address, for both stuck values. It also uses fault pairs whose expected first address depends on the pass order. A FIFO status check that is off by one shows up as a set `flag_fail` once the fill or drain run ends.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_M0, S_M1R, S_M1W, S_M2R, S_M2W, S_FILL, S_DRAIN, S_TAIL, S_NEXT
  } mb_state_e;

  typedef enum logic [1:0] {K_SRAM, K_FILL, K_DRAIN, K_NONE} mb_kind_e;
endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  parameter int NUM_SRAM = 3,
  parameter int IDW = 3,
  parameter logic [NUM_SRAM-1:0] DUAL_MASK = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_all,
  input  logic           start_one,
  input  logic [IDW-1:0] start_id,
  input  logic           pat_ones,
  output logic [IDW-1:0] mem_id,
  output logic           mem_port,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic           mem_re,
  output logic [DW-1:0]  mem_wdata,
  output logic [DW-1:0]  rd_exp,
  output logic           flag_chk,
  output logic           exp_full,
  output logic           exp_empty,
  output logic           clr,
  output logic           busy,
  output logic           done
);
  localparam logic [AW-1:0]  LAST     = AW'(DEPTH - 1);
  localparam logic [IDW-1:0] FILL_ID  = IDW'(NUM_SRAM);
  localparam logic [IDW-1:0] DRAIN_ID = IDW'(NUM_SRAM + 1);
  localparam logic [IDW-1:0] LAST_RAM = IDW'(NUM_SRAM - 1);
  localparam int IDN = 2 ** IDW;
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  function automatic mb_kind_e kind_of(input logic [IDW-1:0] id);
    if (id < IDW'(NUM_SRAM)) return K_SRAM;
    if (id == FILL_ID) return K_FILL;
    if (id == DRAIN_ID) return K_DRAIN;
    return K_NONE;
  endfunction

  mb_state_e      st;
  logic [IDW-1:0] cur_id, launch_id;
  logic           cur_port, all_q, pat_q, start, more_port, more_id;
  logic [AW-1:0]  addr;
  logic [IDN-1:0] dual_vec;
  mb_kind_e       cur_kind, launch_kind;

  assign dual_vec    = IDN'(DUAL_MASK);
  assign start       = (st == S_IDLE) && (start_all || start_one);
  assign launch_id   = start_all ? '0 : start_id;
  assign launch_kind = kind_of(launch_id);
  assign cur_kind    = kind_of(cur_id);
  assign more_port   = (cur_kind == K_SRAM) && dual_vec[cur_id] && !cur_port;
  assign more_id     = all_q && (cur_id != LAST_RAM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_id   <= '0;
      cur_port <= 1'b0;
      all_q    <= 1'b0;
      pat_q    <= 1'b0;
      addr     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          all_q    <= start_all;
          pat_q    <= pat_ones;
          cur_id   <= launch_id;
          cur_port <= 1'b0;
          addr     <= '0;
          unique case (launch_kind)
            K_SRAM:  st <= S_M0;
            K_FILL:  st <= S_FILL;
            K_DRAIN: st <= S_DRAIN;
            default: st <= S_NEXT;
          endcase
        end
        S_M0: begin
          addr <= (addr == LAST) ? '0 : addr + AW'(1);
          if (addr == LAST) st <= S_M1R;
        end
        S_M1R: st <= S_M1W;
        S_M1W: begin
          if (addr == LAST) st <= S_M2R;
          else begin
            addr <= addr + AW'(1);
            st   <= S_M1R;
          end
        end
        S_M2R: st <= S_M2W;
        S_M2W: begin
          if (addr == '0) st <= S_TAIL;
          else begin
            addr <= addr - AW'(1);
            st   <= S_M2R;
          end
        end
        S_FILL, S_DRAIN: begin
          if (addr == LAST) st <= S_TAIL;
          else addr <= addr + AW'(1);
        end
        S_TAIL: st <= S_NEXT;
        S_NEXT: begin
          addr <= '0;
          if (more_port) begin
            cur_port <= 1'b1;
            st       <= S_M0;
          end else if (more_id) begin
            cur_id   <= cur_id + IDW'(1);
            cur_port <= 1'b0;
            st       <= S_M0;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    rd_exp    = '0;
    flag_chk  = 1'b0;
    exp_full  = 1'b0;
    exp_empty = 1'b0;
    unique case (st)
      S_M0:  mem_we = 1'b1;
      S_M1R: mem_re = 1'b1;
      S_M1W: begin mem_we = 1'b1; mem_wdata = ONES; end
      S_M2R: begin mem_re = 1'b1; rd_exp = ONES; end
      S_M2W: mem_we = 1'b1;
      S_FILL: begin
        mem_we    = 1'b1;
        mem_wdata = pat_q ? ONES : '0;
        flag_chk  = 1'b1;
        exp_empty = (addr == '0);
      end
      S_DRAIN: begin
        mem_re   = 1'b1;
        rd_exp   = pat_q ? ONES : '0;
        flag_chk = 1'b1;
        exp_full = (addr == '0);
      end
      S_TAIL: begin
        flag_chk  = (cur_kind == K_FILL) || (cur_kind == K_DRAIN);
        exp_full  = (cur_kind == K_FILL);
        exp_empty = (cur_kind == K_DRAIN);
      end
      default: ;
    endcase
  end

  assign mem_id   = cur_id;
  assign mem_port = cur_port;
  assign mem_addr = addr;
  assign clr      = start;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_NEXT) && !more_port && !more_id;
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  parameter int IDW = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           rd_chk,
  input  logic [AW-1:0]  rd_addr,
  input  logic [DW-1:0]  rd_exp,
  input  logic [IDW-1:0] rd_id,
  input  logic           rd_port,
  input  logic [DW-1:0]  rdata,
  input  logic           flag_chk,
  input  logic           exp_full,
  input  logic           exp_empty,
  input  logic           fifo_full,
  input  logic           fifo_empty,
  output logic           fail,
  output logic [AW-1:0]  fail_addr,
  output logic [IDW-1:0] fail_id,
  output logic           fail_port,
  output logic           flag_fail
);
  logic           chk_q, port_q, mism, flag_bad;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  exp_q;
  logic [IDW-1:0] id_q;

  assign mism     = chk_q && (rdata != exp_q);
  assign flag_bad = flag_chk && ((fifo_full != exp_full) || (fifo_empty != exp_empty));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
      id_q   <= '0;
      port_q <= 1'b0;
    end else begin
      chk_q  <= rd_chk;
      addr_q <= rd_addr;
      exp_q  <= rd_exp;
      id_q   <= rd_id;
      port_q <= rd_port;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_id   <= '0;
      fail_port <= 1'b0;
      flag_fail <= 1'b0;
    end else begin
      if (mism && !fail) begin
        fail      <= 1'b1;
        fail_addr <= addr_q;
        fail_id   <= id_q;
        fail_port <= port_q;
      end
      if (flag_bad) flag_fail <= 1'b1;
    end
  end
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW = 8,
  parameter int NUM_SRAM = 3,
  parameter int IDW = 3,
  parameter logic [NUM_SRAM-1:0] DUAL_MASK = 3'b010,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           id_load,
  input  logic [IDW-1:0] id_value,
  input  logic           pat_ones,
  input  logic           run_all,
  input  logic           run_one,
  output logic           busy,
  output logic           done_irq,
  output logic [IDW-1:0] mem_id,
  output logic           mem_port,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_we,
  output logic           mem_re,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           fifo_full,
  input  logic           fifo_empty,
  output logic           fail,
  output logic [AW-1:0]  fail_addr,
  output logic [IDW-1:0] fail_id,
  output logic           fail_port,
  output logic           flag_fail
);
  logic [IDW-1:0] id_q;
  logic [DW-1:0]  rd_exp;
  logic           flag_chk, exp_full, exp_empty, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) id_q <= '0;
    else if (id_load) id_q <= id_value;
  end

  mbist_seq #(
    .DEPTH(DEPTH), .DW(DW), .NUM_SRAM(NUM_SRAM), .IDW(IDW), .DUAL_MASK(DUAL_MASK)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start_all(run_all), .start_one(run_one),
    .start_id(id_q), .pat_ones(pat_ones),
    .mem_id(mem_id), .mem_port(mem_port), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .rd_exp(rd_exp), .flag_chk(flag_chk), .exp_full(exp_full), .exp_empty(exp_empty),
    .clr(clr), .busy(busy), .done(done_irq)
  );

  mbist_cmp #(.DEPTH(DEPTH), .DW(DW), .IDW(IDW)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rd_chk(mem_re), .rd_addr(mem_addr), .rd_exp(rd_exp),
    .rd_id(mem_id), .rd_port(mem_port), .rdata(mem_rdata),
    .flag_chk(flag_chk), .exp_full(exp_full), .exp_empty(exp_empty),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fail(fail), .fail_addr(fail_addr), .fail_id(fail_id),
    .fail_port(fail_port), .flag_fail(flag_fail)
  );
endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
  parameter int DW = 8,
  parameter int IDW = 3,
  parameter int AW = 3,
  parameter int FILL_ID = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done_irq,
  input logic           run_all,
  input logic           run_one,
  input logic           mem_we,
  input logic           mem_re,
  input logic [IDW-1:0] mem_id,
  input logic [DW-1:0]  mem_wdata,
  input logic           fail,
  input logic [AW-1:0]  fail_addr,
  input logic           flag_fail
);
  logic accept;
  assign accept = !busy && (run_all || run_one);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> busy ##1 !busy);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_fail_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !accept) |=> (fail && $stable(fail_addr)));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_fail && !accept) |=> flag_fail);

  p_fill_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_id == IDW'(FILL_ID)) |-> (mem_wdata == '0 || mem_wdata == '1));
endmodule

bind mbist_ctrl mbist_ctrl_chk #(
  .DW(DW), .IDW(IDW), .AW(AW), .FILL_ID(NUM_SRAM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_irq(done_irq),
  .run_all(run_all), .run_one(run_one), .mem_we(mem_we), .mem_re(mem_re),
  .mem_id(mem_id), .mem_wdata(mem_wdata), .fail(fail), .fail_addr(fail_addr),
  .flag_fail(flag_fail)
);

// File: tb/mbist_ctrl_tb_top.sv
module mbist_ctrl_tb_top;
  localparam int D = 8, W = 8, NS = 3, IW = 3, AW = 3;
  localparam int FILLI = NS, DRAINI = NS + 1;
  localparam int RAM_LAT = 5 * D + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, id_load = 1'b0, pat_ones = 1'b0, run_all = 1'b0, run_one = 1'b0;
  logic [IW-1:0] id_value = '0;
  logic busy, done_irq, mem_port, mem_we, mem_re, fail, fail_port, flag_fail;
  logic [IW-1:0] mem_id, fail_id;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [W-1:0]  mem_wdata;
  logic [W-1:0]  mem_rdata = '0;
  logic fifo_full, fifo_empty;

  mbist_ctrl #(.DEPTH(D), .DW(W), .NUM_SRAM(NS), .IDW(IW), .DUAL_MASK(3'b010)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_load(id_load), .id_value(id_value),
    .pat_ones(pat_ones), .run_all(run_all), .run_one(run_one),
    .busy(busy), .done_irq(done_irq), .mem_id(mem_id), .mem_port(mem_port),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fail(fail), .fail_addr(fail_addr), .fail_id(fail_id), .fail_port(fail_port),
    .flag_fail(flag_fail)
  );

  // memory and FIFO models
  logic [W-1:0] sram [NS][2][D];
  logic [W-1:0] f1 [NS][2][D];
  logic [W-1:0] f0 [NS][2][D];
  logic [W-1:0] fq [D];
  int fcnt = 0, wp = 0, rp = 0, corrupt_at = -1;
  bit bad_full = 0;
  int checks = 0, errors = 0, conflicts = 0;
  bit finished = 0;

  assign fifo_full  = bad_full ? (fcnt >= D - 1) : (fcnt == D);
  assign fifo_empty = (fcnt == 0);

  always @(posedge clk) begin
    int nc;
    nc = fcnt;
    if (mem_we && mem_id < NS) sram[mem_id][mem_port][mem_addr] <= mem_wdata;
    if (mem_re && mem_id < NS)
      mem_rdata <= (sram[mem_id][mem_port][mem_addr] | f1[mem_id][mem_port][mem_addr])
                   & ~f0[mem_id][mem_port][mem_addr];
    if (mem_we && mem_id == FILLI && fcnt < D) begin
      fq[wp] <= mem_wdata;
      wp <= (wp + 1) % D;
      nc = nc + 1;
    end
    if (mem_re && mem_id == DRAINI && fcnt > 0) begin
      mem_rdata <= fq[rp] ^ ((rp == corrupt_at) ? 8'h10 : 8'h00);
      rp <= (rp + 1) % D;
      nc = nc - 1;
    end
    fcnt <= nc;
  end

  always @(negedge clk) if (rst_n && mem_we && mem_re) conflicts++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < NS; i++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < D; a++) begin
          f1[i][p][a] = '0;
          f0[i][p][a] = '0;
        end
  endtask

  task automatic set_id(input int v);
    @(negedge clk);
    id_load = 1'b1;
    id_value = IW'(v);
    @(negedge clk);
    id_load = 1'b0;
  endtask

  // expected strobe of step s in a one-port RAM run
  task automatic check_op(input int s, inout int terr);
    bit ew, er;
    int ea;
    logic [W-1:0] ed;
    ew = 0; er = 0; ed = '0;
    if (s < D) begin
      ew = 1; ea = s;
    end else if (s < 3 * D) begin
      ea = (s - D) / 2;
      if ((s - D) % 2 == 0) er = 1; else begin ew = 1; ed = '1; end
    end else begin
      ea = D - 1 - (s - 3 * D) / 2;
      if ((s - 3 * D) % 2 == 0) er = 1; else ew = 1;
    end
    if (mem_we != ew || mem_re != er || int'(mem_addr) != ea || mem_port != 1'b0 ||
        (ew && mem_wdata != ed)) terr++;
  endtask

  task automatic run(input bit all, input bit trace, input bit inject,
                     input int exp_lat, input int exp_strb, input string req);
    int k, irqs, lat, strb, terr;
    k = 1; irqs = 0; lat = -1; strb = 0; terr = 0;
    @(negedge clk);
    if (all) run_all = 1'b1; else run_one = 1'b1;
    @(negedge clk);
    run_all = 1'b0;
    run_one = 1'b0;
    while (k < 4000) begin
      if (trace && k <= 5 * D) check_op(k - 1, terr);
      if (mem_we || mem_re) strb++;
      if (done_irq) begin
        irqs++;
        if (lat < 0) lat = k;
      end
      if (!busy) break;
      if (inject && k == 5) run_one = 1'b1;
      @(negedge clk);
      run_one = 1'b0;
      k++;
    end
    chk(lat == exp_lat, req, "interrupt cycle", lat, exp_lat);
    chk(irqs == 1, "R10", "interrupt count", irqs, 1);
    chk(strb == exp_strb, req, "strobe cycles", strb, exp_strb);
    if (trace) chk(terr == 0, "R2", "march strobe mismatches", terr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_faults();
    for (int i = 0; i < NS; i++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < D; a++) sram[i][p][a] = '0;
    for (int a = 0; a < D; a++) fq[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done_irq && !mem_we && !mem_re, "R1", "idle outputs",
        {busy, done_irq, mem_we, mem_re}, 0);
    chk(!fail && !flag_fail, "R1", "status after reset", {fail, flag_fail}, 0);

    // R2 clean march on target 0
    set_id(0);
    run(0, 1, 0, RAM_LAT, 5 * D, "R2");
    chk(fail == 0, "R3", "clean run fail", fail, 0);

    // R3 sweep: stuck bit at every address, both polarities
    for (int a = 0; a < D; a++)
      for (int v = 0; v < 2; v++) begin
        clear_faults();
        if (v == 1) f1[0][0][a] = 8'h04; else f0[0][0][a] = 8'h20;
        run(0, 0, 0, RAM_LAT, 5 * D, "R2");
        chk(fail == 1, "R3", "stuck fail flag", fail, 1);
        chk(int'(fail_addr) == a, "R3", "stuck fail addr", fail_addr, a);
        chk(fail_id == 0, "R3", "stuck fail id", fail_id, 0);
      end

    // R3 first mismatch kept: two stuck-at-0 cells, falling pass hits 6 first
    clear_faults();
    f0[0][0][2] = 8'h01;
    f0[0][0][6] = 8'h01;
    run(0, 0, 0, RAM_LAT, 5 * D, "R2");
    chk(int'(fail_addr) == 6, "R3", "first of two stuck-0", fail_addr, 6);
    // R3 rising pass comes before falling pass
    clear_faults();
    f1[0][0][6] = 8'h80;
    f0[0][0][1] = 8'h80;
    run(0, 0, 0, RAM_LAT, 5 * D, "R2");
    chk(int'(fail_addr) == 6, "R3", "pass order first fail", fail_addr, 6);
    // R3 cleared by next command
    clear_faults();
    run(0, 0, 0, RAM_LAT, 5 * D, "R2");
    chk(fail == 0, "R3", "fail cleared on new command", fail, 0);

    // R6 dual-port target 1, fault only on port 1
    set_id(1);
    f1[1][1][3] = 8'h02;
    run(0, 0, 0, 2 * RAM_LAT, 10 * D, "R6");
    chk(fail == 1 && fail_port == 1, "R6", "fail port", fail_port, 1);
    chk(fail_id == 1 && int'(fail_addr) == 3, "R6", "fail addr", fail_addr, 3);

    // R5 walk ignores target register
    clear_faults();
    set_id(7);
    run(1, 0, 0, 4 * RAM_LAT, 20 * D, "R5");
    chk(fail == 0, "R5", "clean walk", fail, 0);
    f1[2][0][4] = 8'h10;
    run(1, 0, 0, 4 * RAM_LAT, 20 * D, "R5");
    chk(fail_id == 2 && int'(fail_addr) == 4, "R5", "walk fail id", fail_id, 2);
    f1[1][1][0] = 8'h10;
    run(1, 0, 0, 4 * RAM_LAT, 20 * D, "R5");
    chk(fail_id == 1 && fail_port == 1, "R5", "walk order first fail id", fail_id, 1);
    clear_faults();

    // R4 out-of-range target
    run(0, 0, 0, 1, 0, "R4");
    chk(fail == 0 && flag_fail == 0, "R4", "no status from empty run", fail, 0);

    // R10 command while busy is ignored
    set_id(0);
    run(0, 0, 1, RAM_LAT, 5 * D, "R10");

    // R7 fill ones, R8 drain ones
    pat_ones = 1'b1;
    set_id(FILLI);
    run(0, 0, 0, D + 2, D, "R7");
    begin
      int bad = 0;
      for (int a = 0; a < D; a++) if (fq[a] != 8'hFF) bad++;
      chk(bad == 0 && fcnt == D, "R7", "words not all ones", bad, 0);
    end
    chk(flag_fail == 0, "R9", "fill flags good", flag_fail, 0);
    set_id(DRAINI);
    run(0, 0, 0, D + 2, D, "R8");
    chk(fail == 0 && flag_fail == 0 && fcnt == 0, "R8", "clean drain", fail, 0);

    // R7 fill zeros, R8 drain expecting ones fails at index 0
    pat_ones = 1'b0;
    set_id(FILLI);
    run(0, 0, 0, D + 2, D, "R7");
    begin
      int bad = 0;
      for (int a = 0; a < D; a++) if (fq[a] != 8'h00) bad++;
      chk(bad == 0, "R7", "words not all zeros", bad, 0);
    end
    pat_ones = 1'b1;
    set_id(DRAINI);
    run(0, 0, 0, D + 2, D, "R8");
    chk(fail == 1 && fail_addr == 0, "R8", "pattern mismatch index", fail_addr, 0);

    // R8 one corrupted word at index 5
    set_id(FILLI);
    run(0, 0, 0, D + 2, D, "R7");
    corrupt_at = 5;
    set_id(DRAINI);
    run(0, 0, 0, D + 2, D, "R8");
    chk(fail == 1 && int'(fail_addr) == 5, "R8", "corrupt index", fail_addr, 5);
    chk(flag_fail == 0, "R9", "data error leaves flags", flag_fail, 0);
    corrupt_at = -1;

    // R9 full asserted one word early
    bad_full = 1;
    set_id(FILLI);
    run(0, 0, 0, D + 2, D, "R7");
    chk(flag_fail == 1, "R9", "early full detected", flag_fail, 1);
    chk(fail == 0, "R9", "flag error leaves data fail", fail, 0);
    bad_full = 0;
    set_id(DRAINI);
    run(0, 0, 0, D + 2, D, "R8");
    chk(flag_fail == 0 && fail == 0, "R9", "good drain after fix", flag_fail, 0);

    chk(conflicts == 0, "R11", "write and read together", conflicts, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule